// File: doc/BRIEF.md
# Two-Key Register Write Guard

This block stands between a register write port and two protected registers: a control register and an option register. Each protected register has its own key register and its own lock state. A register starts out locked. It opens only after its key register receives two fixed 32-bit words, the first word and then the second, with no other accepted write between them. Any departure from that sequence raises a bus error and puts that register into a lockout that only a reset clears.

When a protected register is open, writes to it pass through to the register as a write strobe. Writing a 1 to its lock bit closes it again. Writes to a closed register are dropped and answered with a bus error. While the busy input is high, a write to the control register stalls the port until busy falls. Writes to the option register never stall.

Top module: `key_unlock_guard`

## Requirements
- R1: After reset both registers are locked (`ctrl_lock_o`=1, `opt_lock_o`=1), neither is in lockout, and `bus_err_o` and `stall_o` are 0.
- R2: The control register opens when its key register (word address 0) receives 0x45670123 and then 0xCDEF89AB as consecutive accepted writes. `ctrl_lock_o` falls in the cycle after the second write.
- R3: The option register opens when its key register (word address 1) receives 0x08192A3B and then 0x4C5D6E7F as consecutive accepted writes. The control keys written to that address count as wrong keys.
- R4: A wrong word written to a key register raises a bus error and sets that register's lockout. While in lockout, the register stays locked even after the correct key pair is written, until reset.
- R5: Between the first and second key, any other accepted write anywhere on the port sets lockout and raises a bus error for the half-unlocked register.
- R6: A key write to a register that is already open sets lockout for that register, raises a bus error, and relocks it.
- R7: A write to a locked register (control at word address 2, option at word address 3) produces no write strobe and raises a bus error. It leaves the lock and lockout state unchanged.
- R8: A write to an open register produces a write strobe in the same cycle. When the lock bit is 1 (bit 31 for control, bit 0 for option), the register relocks without lockout. When the lock bit is 0, the register stays open.
- R9: While `busy_i` is high, a write to the control register holds `stall_o` high, produces no strobe and changes no state. The write completes in the cycle busy falls. Option register writes do not stall.
- R10: The lockout of each register is independent: one register in lockout does not stop the other from being unlocked.
- R11: `bus_err_o` is registered. It is high for exactly the one cycle after each offending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, held until accepted |
| waddr_i | input | 4 | Word address of the write |
| wdata_i | input | 32 | Write data |
| busy_i | input | 1 | Flash operation in progress |
| stall_o | output | 1 | Current write is held off |
| bus_err_o | output | 1 | Error response for the previous write |
| ctrl_lock_o | output | 1 | Control register locked |
| opt_lock_o | output | 1 | Option register locked |
| ctrl_lockout_o | output | 1 | Control register locked until reset |
| opt_lockout_o | output | 1 | Option register locked until reset |
| ctrl_wr_en_o | output | 1 | Write strobe to the control register |
| opt_wr_en_o | output | 1 | Write strobe to the option register |

## Verification
The bench targets the sequence breakers: a foreign write between the two keys, a repeat key write to an open register, and the other register's keys written to the wrong key address. A design that only restarted the sequence would let a later correct pair unlock the register, and the bench would see the register open. It checks that lockout persists through a correct pair and stays per register, so a shared lockout would stop the second register from opening. It holds a control write under busy for several cycles and checks that no strobe or relock slips through early and that the write lands exactly when busy falls. It also checks that an option write under busy is not stalled.

// File: rtl/key_guard_pkg.sv
package key_guard_pkg;
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2,
    KS_FROZEN = 2'd3
  } key_state_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_CTRL = 0;
  localparam int unsigned CH_OPT  = 1;
endpackage

// File: rtl/kg_decode.sv
module kg_decode #(
  parameter int unsigned NCH    = 2,
  parameter int unsigned ADDR_W = 4,
  parameter logic [NCH-1:0][ADDR_W-1:0] KEY_ADDRS  = '0,
  parameter logic [NCH-1:0][ADDR_W-1:0] REG_ADDRS  = '0,
  parameter logic [NCH-1:0]             STALL_MASK = '0
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              busy_i,
  output logic [NCH-1:0]    key_hit_o,
  output logic [NCH-1:0]    reg_hit_o,
  output logic [NCH-1:0]    other_hit_o,
  output logic              stall_o
);
  logic [NCH-1:0] key_match, reg_match, stall_req;
  logic           accept;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign key_match[i] = (waddr_i == KEY_ADDRS[i]);
    assign reg_match[i] = (waddr_i == REG_ADDRS[i]);
    assign stall_req[i] = STALL_MASK[i] & reg_match[i];
  end

  assign stall_o = we_i & busy_i & (|stall_req);
  assign accept  = we_i & ~stall_o;

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign key_hit_o[i]   = accept & key_match[i];
    assign reg_hit_o[i]   = accept & reg_match[i];
    assign other_hit_o[i] = accept & ~key_match[i] & ~reg_match[i];
  end
endmodule

// File: rtl/kg_channel.sv
module kg_channel
  import key_guard_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter logic [DATA_W-1:0] KEY_A    = '0,
  parameter logic [DATA_W-1:0] KEY_B    = '0,
  parameter int unsigned       LOCK_POS = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic              reg_wr_i,
  input  logic              other_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o,
  output logic              lockout_o,
  output logic              err_o,
  output logic              wr_en_o
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    err_o   = 1'b0;
    wr_en_o = 1'b0;
    unique case (st_q)
      KS_LOCKED: begin
        if (key_wr_i) begin
          if (wdata_i == KEY_A) st_d = KS_HALF;
          else begin
            st_d  = KS_FROZEN;
            err_o = 1'b1;
          end
        end else if (reg_wr_i) begin
          err_o = 1'b1;
        end
      end
      KS_HALF: begin
        if (key_wr_i) begin
          if (wdata_i == KEY_B) st_d = KS_OPEN;
          else begin
            st_d  = KS_FROZEN;
            err_o = 1'b1;
          end
        end else if (reg_wr_i || other_wr_i) begin
          // sequence broken by an intervening write
          st_d  = KS_FROZEN;
          err_o = 1'b1;
        end
      end
      KS_OPEN: begin
        if (key_wr_i) begin
          st_d  = KS_FROZEN;
          err_o = 1'b1;
        end else if (reg_wr_i) begin
          wr_en_o = 1'b1;
          if (wdata_i[LOCK_POS]) st_d = KS_LOCKED;
        end
      end
      KS_FROZEN: begin
        if (key_wr_i || reg_wr_i) err_o = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KS_LOCKED;
    else         st_q <= st_d;
  end

  assign locked_o  = (st_q != KS_OPEN);
  assign lockout_o = (st_q == KS_FROZEN);
endmodule

// File: rtl/kg_err_reg.sv
module kg_err_reg #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] err_i,
  output logic           bus_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_err_o <= 1'b0;
    else         bus_err_o <= |err_i;
  end
endmodule

// File: rtl/key_unlock_guard.sv
module key_unlock_guard
  import key_guard_pkg::*;
#(
  parameter int unsigned       DATA_W        = 32,
  parameter int unsigned       ADDR_W        = 4,
  parameter int unsigned       CTRL_KEY_ADDR = 0,
  parameter int unsigned       OPT_KEY_ADDR  = 1,
  parameter int unsigned       CTRL_REG_ADDR = 2,
  parameter int unsigned       OPT_REG_ADDR  = 3,
  parameter logic [DATA_W-1:0] CTRL_KEY1     = 32'h4567_0123,
  parameter logic [DATA_W-1:0] CTRL_KEY2     = 32'hCDEF_89AB,
  parameter logic [DATA_W-1:0] OPT_KEY1      = 32'h0819_2A3B,
  parameter logic [DATA_W-1:0] OPT_KEY2      = 32'h4C5D_6E7F,
  parameter int unsigned       CTRL_LOCK_POS = 31,
  parameter int unsigned       OPT_LOCK_POS  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic              stall_o,
  output logic              bus_err_o,
  output logic              ctrl_lock_o,
  output logic              opt_lock_o,
  output logic              ctrl_lockout_o,
  output logic              opt_lockout_o,
  output logic              ctrl_wr_en_o,
  output logic              opt_wr_en_o
);
  localparam int unsigned NCH = NUM_CH;
  localparam logic [NCH-1:0][ADDR_W-1:0] KEY_ADDR_TAB =
    {ADDR_W'(OPT_KEY_ADDR), ADDR_W'(CTRL_KEY_ADDR)};
  localparam logic [NCH-1:0][ADDR_W-1:0] REG_ADDR_TAB =
    {ADDR_W'(OPT_REG_ADDR), ADDR_W'(CTRL_REG_ADDR)};
  localparam logic [NCH-1:0][DATA_W-1:0] KEY_A_TAB = {OPT_KEY1, CTRL_KEY1};
  localparam logic [NCH-1:0][DATA_W-1:0] KEY_B_TAB = {OPT_KEY2, CTRL_KEY2};
  localparam int unsigned LOCK_POS_TAB [NCH] = '{CTRL_LOCK_POS, OPT_LOCK_POS};
  localparam logic [NCH-1:0] STALL_TAB = NCH'(1) << CH_CTRL;

  logic [NCH-1:0] key_hit, reg_hit, other_hit;
  logic [NCH-1:0] locked, lockout, err, wr_en;

  kg_decode #(
    .NCH       (NCH),
    .ADDR_W    (ADDR_W),
    .KEY_ADDRS (KEY_ADDR_TAB),
    .REG_ADDRS (REG_ADDR_TAB),
    .STALL_MASK(STALL_TAB)
  ) u_decode (
    .we_i       (we_i),
    .waddr_i    (waddr_i),
    .busy_i     (busy_i),
    .key_hit_o  (key_hit),
    .reg_hit_o  (reg_hit),
    .other_hit_o(other_hit),
    .stall_o    (stall_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    kg_channel #(
      .DATA_W  (DATA_W),
      .KEY_A   (KEY_A_TAB[i]),
      .KEY_B   (KEY_B_TAB[i]),
      .LOCK_POS(LOCK_POS_TAB[i])
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .key_wr_i  (key_hit[i]),
      .reg_wr_i  (reg_hit[i]),
      .other_wr_i(other_hit[i]),
      .wdata_i   (wdata_i),
      .locked_o  (locked[i]),
      .lockout_o (lockout[i]),
      .err_o     (err[i]),
      .wr_en_o   (wr_en[i])
    );
  end

  kg_err_reg #(.NCH(NCH)) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .err_i    (err),
    .bus_err_o(bus_err_o)
  );

  assign ctrl_lock_o    = locked[CH_CTRL];
  assign opt_lock_o     = locked[CH_OPT];
  assign ctrl_lockout_o = lockout[CH_CTRL];
  assign opt_lockout_o  = lockout[CH_OPT];
  assign ctrl_wr_en_o   = wr_en[CH_CTRL];
  assign opt_wr_en_o    = wr_en[CH_OPT];
endmodule

// File: rtl/key_unlock_guard_chk.sv
module key_unlock_guard_chk #(
  parameter int unsigned       DATA_W        = 32,
  parameter int unsigned       ADDR_W        = 4,
  parameter int unsigned       CTRL_KEY_ADDR = 0,
  parameter int unsigned       OPT_KEY_ADDR  = 1,
  parameter logic [DATA_W-1:0] CTRL_KEY2     = '0,
  parameter logic [DATA_W-1:0] OPT_KEY2      = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              busy_i,
  input logic              stall_o,
  input logic              bus_err_o,
  input logic              ctrl_lock_o,
  input logic              opt_lock_o,
  input logic              ctrl_lockout_o,
  input logic              opt_lockout_o,
  input logic              ctrl_wr_en_o,
  input logic              opt_wr_en_o
);
  AST_CTRL_UNLOCK_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_lock_o) |-> $past(we_i && waddr_i == ADDR_W'(CTRL_KEY_ADDR) && wdata_i == CTRL_KEY2)); // R2
  AST_OPT_UNLOCK_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(opt_lock_o) |-> $past(we_i && waddr_i == ADDR_W'(OPT_KEY_ADDR) && wdata_i == OPT_KEY2)); // R3
  AST_CTRL_LOCKOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_lockout_o |=> (ctrl_lockout_o && ctrl_lock_o)); // R4
  AST_OPT_LOCKOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_lockout_o |=> (opt_lockout_o && opt_lock_o)); // R4
  AST_CTRL_STROBE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_en_o |-> !ctrl_lock_o); // R7
  AST_OPT_STROBE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_wr_en_o |-> !opt_lock_o); // R7
  AST_STALL_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!ctrl_wr_en_o && busy_i)); // R9
  AST_STALL_KEEPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !opt_lock_o) |=> $stable(ctrl_lock_o)); // R9
  AST_ERR_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> $past(we_i && !stall_o)); // R11
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ctrl_wr_en_o, opt_wr_en_o}) <= 1); // R8
endmodule

bind key_unlock_guard key_unlock_guard_chk #(
  .DATA_W       (DATA_W),
  .ADDR_W       (ADDR_W),
  .CTRL_KEY_ADDR(CTRL_KEY_ADDR),
  .OPT_KEY_ADDR (OPT_KEY_ADDR),
  .CTRL_KEY2    (CTRL_KEY2),
  .OPT_KEY2     (OPT_KEY2)
) u_chk (.*);

// File: tb/key_unlock_guard_tb_top.sv
module key_unlock_guard_tb_top;
  localparam logic [31:0] CK1 = 32'h4567_0123;
  localparam logic [31:0] CK2 = 32'hCDEF_89AB;
  localparam logic [31:0] OK1 = 32'h0819_2A3B;
  localparam logic [31:0] OK2 = 32'h4C5D_6E7F;
  localparam logic [3:0] A_CKEY = 4'd0, A_OKEY = 4'd1, A_CREG = 4'd2, A_OREG = 4'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] waddr = '0;
  logic [31:0] wdata = '0;
  logic busy = 1'b0;
  logic stall, bus_err, c_lock, o_lock, c_out, o_out, c_en, o_en;
  logic s_cen, s_oen, s_stall;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  key_unlock_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .busy_i(busy), .stall_o(stall), .bus_err_o(bus_err), .ctrl_lock_o(c_lock),
    .opt_lock_o(o_lock), .ctrl_lockout_o(c_out), .opt_lockout_o(o_out),
    .ctrl_wr_en_o(c_en), .opt_wr_en_o(o_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    we = 1'b0; busy = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive at negedge, sample strobes mid-cycle, sample registered outputs next negedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    #1;
    s_cen = c_en; s_oen = o_en; s_stall = stall;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 ctrl_lock", 32'(c_lock), 1);
    check("R1 opt_lock", 32'(o_lock), 1);
    check("R1 lockouts", {30'b0, c_out, o_out}, 0);
    check("R1 bus_err", 32'(bus_err), 0);
    check("R1 stall", 32'(stall), 0);
  endtask

  task automatic t_ctrl_unlock();
    do_reset();
    wr(A_CKEY, CK1);
    check("R2 still locked after first key", 32'(c_lock), 1);
    check("R2 no error after first key", 32'(bus_err), 0);
    wr(A_CKEY, CK2);
    check("R2 ctrl open", 32'(c_lock), 0);
    check("R2 opt untouched", 32'(o_lock), 1);
    check("R2 no error", 32'(bus_err), 0);
  endtask

  task automatic t_opt_unlock();
    do_reset();
    wr(A_OKEY, OK1);
    wr(A_OKEY, OK2);
    check("R3 opt open", 32'(o_lock), 0);
    check("R3 ctrl still locked", 32'(c_lock), 1);
    do_reset();
    wr(A_OKEY, CK1);
    check("R3 ctrl key on opt addr errors", 32'(bus_err), 1);
    check("R3 opt lockout", 32'(o_out), 1);
  endtask

  task automatic t_wrong_key();
    do_reset();
    wr(A_CKEY, 32'h1234_5678);
    check("R4 wrong key error", 32'(bus_err), 1);
    check("R4 lockout set", 32'(c_out), 1);
    wr(A_CKEY, CK1);
    check("R4 error on key during lockout", 32'(bus_err), 1);
    wr(A_CKEY, CK2);
    check("R4 correct pair ignored in lockout", 32'(c_lock), 1);
    wr(A_CREG, 32'h0);
    check("R4 no strobe in lockout", 32'(s_cen), 0);
    do_reset();
    check("R4 reset clears lockout", 32'(c_out), 0);
    wr(A_CKEY, CK1);
    wr(A_CKEY, CK2);
    check("R4 unlock after reset", 32'(c_lock), 0);
  endtask

  task automatic t_intervening();
    do_reset();
    wr(A_CKEY, CK1);
    wr(A_OKEY, OK1);
    check("R5 intervening write errors", 32'(bus_err), 1);
    check("R5 ctrl lockout", 32'(c_out), 1);
    wr(A_OKEY, OK2);
    check("R10 opt unlocks beside ctrl lockout", 32'(o_lock), 0);
    check("R10 opt not in lockout", 32'(o_out), 0);
    check("R10 ctrl still locked", 32'(c_lock), 1);
    wr(A_OREG, 32'h0);
    check("R10 opt strobe", 32'(s_oen), 1);
  endtask

  task automatic t_rekey_open();
    do_reset();
    wr(A_CKEY, CK1);
    wr(A_CKEY, CK2);
    wr(A_CKEY, CK1);
    check("R6 key on open errors", 32'(bus_err), 1);
    check("R6 lockout", 32'(c_out), 1);
    check("R6 relocked", 32'(c_lock), 1);
    @(negedge clk);
    check("R11 error lasts one cycle", 32'(bus_err), 0);
  endtask

  task automatic t_locked_write();
    do_reset();
    wr(A_CREG, 32'h0);
    check("R7 no strobe when locked", 32'(s_cen), 0);
    check("R7 error on locked write", 32'(bus_err), 1);
    check("R7 no lockout", 32'(c_out), 0);
    check("R7 still locked", 32'(c_lock), 1);
    wr(A_CKEY, CK1);
    wr(A_CKEY, CK2);
    check("R7 unlock still possible", 32'(c_lock), 0);
  endtask

  task automatic t_relock();
    do_reset();
    wr(A_CKEY, CK1);
    wr(A_CKEY, CK2);
    wr(A_CREG, 32'h7FFF_FFFF);
    check("R8 strobe when open", 32'(s_cen), 1);
    check("R8 lock bit 0 keeps open", 32'(c_lock), 0);
    check("R8 no error", 32'(bus_err), 0);
    wr(A_CREG, 32'h8000_0000);
    check("R8 strobe on relock write", 32'(s_cen), 1);
    check("R8 lock bit 1 relocks", 32'(c_lock), 1);
    check("R8 no lockout on relock", 32'(c_out), 0);
    wr(A_CKEY, CK1);
    wr(A_CKEY, CK2);
    check("R8 reopen after relock", 32'(c_lock), 0);
    wr(A_OKEY, OK1);
    wr(A_OKEY, OK2);
    wr(A_OREG, 32'h1);
    check("R8 opt relock via bit 0", 32'(o_lock), 1);
  endtask

  task automatic t_busy();
    do_reset();
    wr(A_CKEY, CK1);
    wr(A_CKEY, CK2);
    @(negedge clk);
    busy = 1'b1; we = 1'b1; waddr = A_CREG; wdata = 32'h8000_0000;
    #1;
    check("R9 stall raised", 32'(stall), 1);
    check("R9 no strobe while stalled", 32'(c_en), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 stall held", 32'(stall), 1);
      check("R9 lock unchanged while stalled", 32'(c_lock), 0);
    end
    busy = 1'b0;
    #1;
    check("R9 stall released", 32'(stall), 0);
    check("R9 strobe on release", 32'(c_en), 1);
    @(negedge clk);
    we = 1'b0;
    check("R9 write landed", 32'(c_lock), 1);
    wr(A_OKEY, OK1);
    wr(A_OKEY, OK2);
    busy = 1'b1;
    wr(A_OREG, 32'h1);
    busy = 1'b0;
    check("R9 opt write not stalled", 32'(s_stall), 0);
    check("R9 opt strobe under busy", 32'(s_oen), 1);
    check("R9 opt relocked", 32'(o_lock), 1);
  endtask

  initial begin
    t_reset();
    t_ctrl_unlock();
    t_opt_unlock();
    t_wrong_key();
    t_intervening();
    t_rekey_open();
    t_locked_write();
    t_relock();
    t_busy();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule